// File: doc/BRIEF.md
# UART Transmit Path with Holding-Empty Status and Interrupt

This block is the transmit half of a classic PC-style serial port. The CPU writes characters into transmit storage. The storage is either a single holding register (character mode, the state after reset) or a 16-deep FIFO (FIFO mode, selected by writing the FIFO-enable control bit). A shift register takes one character at a time from the storage and sends it as an 8N1 frame. The frame advances one bit on each pulse of an external baud-tick enable.

The block tells software when it may write more data. The line-status byte carries a holding-empty flag and a transmitter-empty flag. The interrupt-identification byte reports a pending holding-empty interrupt, and the `irq` output raises it. Software clears that interrupt either by writing another character or by reading the identification byte. After that, only a new transition to empty raises it again.

Top module: `uart_thre_tx`

## Requirements
- R1: After reset the block is in character mode, `lsr` reads 8'h60 (bit 5 holding-empty = 1, bit 6 transmitter-empty = 1, all other bits 0), `iir` reads 8'h01, `irq` is 0 and `txd` is 1.
- R2: In character mode the storage holds one character. Bit 5 of `lsr` reads 0 from the clock edge that accepts a `thr_wr` until the edge that moves the character into the shift register, and reads 1 from that edge on. A `thr_wr` while the holding register is occupied is ignored.
- R3: A `fcr_wr` with `fcr_fifo_en`=1 selects FIFO mode, in which up to 16 characters wait behind the shift register. In this mode bit 5 of `lsr` is 1 exactly when the FIFO is empty. A `thr_wr` while 16 characters wait is ignored.
- R4: When the enable bit (`ier_thre_en`, interrupt-enable bit 1) is 1, `irq` goes to 1 on the edge after the storage becomes empty through a transfer to the shift register or through a flush. It also goes to 1 when the enable bit changes from 0 to 1 while bit 5 of `lsr` is 1. While the enable is 0, `irq` stays 0.
- R5: `iir` bits 3:0 read 4'b0010 while the interrupt is pending and 4'b0001 otherwise. Bits 7:6 read 2'b11 in FIFO mode and 2'b00 in character mode. Bits 5:4 read 0.
- R6: A pending interrupt is cleared on the edge that samples `thr_wr` or `iir_rd` high. After an `iir_rd` clear it is not raised again until a new empty event as defined in R4.
- R7: `txd` idles at 1. Each frame is one start bit of 0, then eight data bits least significant first, then one stop bit of 1. Each bit is held until the next `baud_tick` pulse.
- R8: Bit 6 of `lsr` is 1 only when the storage is empty and the shift register is not sending.
- R9: A `fcr_wr` that changes the mode discards every character waiting in the storage. The character already in the shift register is still sent in full.
- R10: Characters leave on `txd` in the order in which they were accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| thr_wr | input | 1 | Write strobe for the transmit holding register / FIFO |
| thr_data | input | 8 | Character to transmit |
| fcr_wr | input | 1 | Write strobe for the FIFO control register |
| fcr_fifo_en | input | 1 | FIFO control bit 0: 1 selects FIFO mode, 0 selects character mode |
| ier_wr | input | 1 | Write strobe for the interrupt-enable register |
| ier_thre_en | input | 1 | Interrupt-enable bit 1: holding-empty interrupt enable |
| iir_rd | input | 1 | One-cycle pulse marking a read of the interrupt-identification byte |
| baud_tick | input | 1 | One-cycle enable per serial bit time |
| lsr | output | 8 | Line status byte (bit 5 holding-empty, bit 6 transmitter-empty) |
| iir | output | 8 | Interrupt identification byte |
| irq | output | 1 | Holding-empty interrupt request |
| txd | output | 1 | Serial output |

## Verification
The bench checks that the holding-empty flag stays low for exactly one cycle after a lone write in character mode. A design that kept the flag tied to the shift register would instead hold it low for a whole frame. The bench writes past capacity in both modes and compares the received frames against the accepted characters. Storage that overwrote a waiting character, or accepted a 17th entry in the FIFO, would show up as an extra or missing byte. After an identification read the bench waits through a complete frame and expects `irq` to stay low. It then expects `irq` to rise again after a fresh write drains. An interrupt driven only by the level of the empty flag would fire again at once, and one that only a write could clear would never fall. The bench also switches modes with characters waiting and checks that only the character already in the shift register reaches the line.

// File: rtl/uart_thre_pkg.sv
package uart_thre_pkg;
  localparam logic [3:0] IIR_NONE = 4'b0001;
  localparam logic [3:0] IIR_THRE = 4'b0010;
  localparam int LSR_THRE_BIT = 5;
  localparam int LSR_TEMT_BIT = 6;
  typedef enum logic {MODE_CHAR = 1'b0, MODE_FIFO = 1'b1} tx_mode_e;
endpackage

// File: rtl/txq_store.sv
module txq_store #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16
) (
  input  logic                      clk,
  input  logic                      rst,
  input  uart_thre_pkg::tx_mode_e   mode,
  input  logic                      push,
  input  logic [DATA_W-1:0]         push_data,
  input  logic                      pop,
  input  logic                      flush,
  output logic [DATA_W-1:0]         pop_data,
  output logic                      empty,
  output logic                      going_empty
);
  import uart_thre_pkg::*;
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wr_ptr, rd_ptr;
  logic [CW-1:0]     count;
  logic [CW-1:0]     cap;
  logic              push_ok, pop_ok;

  assign cap     = (mode == MODE_FIFO) ? CW'(DEPTH) : CW'(1);
  assign empty   = (count == '0);
  assign push_ok = push && (count < cap) && !flush;
  assign pop_ok  = pop && !empty && !flush;
  assign going_empty = (flush && !empty) ||
                       (pop_ok && !push_ok && count == CW'(1));
  assign pop_data = mem[rd_ptr];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // storage without reset so a RAM primitive can be inferred
  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= nxt(wr_ptr);
      if (pop_ok)  rd_ptr <= nxt(rd_ptr);
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));
  // R2
  char_cap_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_CHAR) |-> (count <= CW'(1)));
endmodule

// File: rtl/txq_shifter.sv
module txq_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  output logic              busy,
  output logic              txd
);
  localparam int FW  = DATA_W + 2;
  localparam int BCW = $clog2(FW + 1);

  logic [FW-1:0]  shreg;
  logic [BCW-1:0] bits_left;

  assign busy = (bits_left != '0);
  assign txd  = shreg[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg     <= '1;
      bits_left <= '0;
    end else if (load && !busy) begin
      shreg     <= {1'b1, load_data, 1'b0};
      bits_left <= BCW'(FW);
    end else if (busy && tick) begin
      shreg     <= {1'b1, shreg[FW-1:1]};
      bits_left <= bits_left - 1'b1;
    end
  end

  // R7
  start_bit_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> !txd);
  // R7
  bit_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(busy) && !$past(tick)) |-> $stable(txd));
endmodule

// File: rtl/thre_irq.sv
module thre_irq (
  input  logic clk,
  input  logic rst,
  input  logic empty_evt,
  input  logic thre,
  input  logic ier_wr,
  input  logic ier_bit,
  input  logic data_wr,
  input  logic iir_rd,
  output logic pend
);
  logic ier_q, ier_next, set_p, clr_p;

  assign ier_next = ier_wr ? ier_bit : ier_q;
  assign set_p = ier_next && (empty_evt || (ier_wr && ier_bit && !ier_q && thre));
  assign clr_p = data_wr || iir_rd || !ier_next;

  always_ff @(posedge clk) begin
    if (rst) begin
      ier_q <= 1'b0;
      pend  <= 1'b0;
    end else begin
      ier_q <= ier_next;
      if (clr_p)      pend <= 1'b0;
      else if (set_p) pend <= 1'b1;
    end
  end

  // R6
  ack_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (iir_rd || data_wr) |=> !pend);
  // R4
  enable_gate_chk: assert property (@(posedge clk) disable iff (rst)
    pend |-> ier_q);
endmodule

// File: rtl/uart_thre_tx.sv
module uart_thre_tx #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              thr_wr,
  input  logic [DATA_W-1:0] thr_data,
  input  logic              fcr_wr,
  input  logic              fcr_fifo_en,
  input  logic              ier_wr,
  input  logic              ier_thre_en,
  input  logic              iir_rd,
  input  logic              baud_tick,
  output logic [7:0]        lsr,
  output logic [7:0]        iir,
  output logic              irq,
  output logic              txd
);
  import uart_thre_pkg::*;

  tx_mode_e          mode_q;
  logic              flush, load, st_empty, going_empty, sh_busy, pend;
  logic [DATA_W-1:0] head;

  assign flush = fcr_wr && (tx_mode_e'(fcr_fifo_en) != mode_q);
  assign load  = !sh_busy && !st_empty && !flush;

  always_ff @(posedge clk) begin
    if (rst)         mode_q <= MODE_CHAR;
    else if (fcr_wr) mode_q <= tx_mode_e'(fcr_fifo_en);
  end

  txq_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst(rst), .mode(mode_q), .push(thr_wr), .push_data(thr_data),
    .pop(load), .flush(flush), .pop_data(head), .empty(st_empty),
    .going_empty(going_empty));

  txq_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst(rst), .tick(baud_tick), .load(load), .load_data(head),
    .busy(sh_busy), .txd(txd));

  thre_irq u_irq (
    .clk(clk), .rst(rst), .empty_evt(going_empty), .thre(st_empty),
    .ier_wr(ier_wr), .ier_bit(ier_thre_en), .data_wr(thr_wr), .iir_rd(iir_rd),
    .pend(pend));

  always_comb begin
    lsr = '0;
    lsr[LSR_THRE_BIT] = st_empty;
    lsr[LSR_TEMT_BIT] = st_empty && !sh_busy;
    iir = {{2{mode_q == MODE_FIFO}}, 2'b00, pend ? IIR_THRE : IIR_NONE};
  end
  assign irq = pend;

  // R8
  temt_chk: assert property (@(posedge clk) disable iff (rst)
    lsr[LSR_TEMT_BIT] |-> (lsr[LSR_THRE_BIT] && txd));
endmodule

// File: tb/uart_thre_tx_bench.sv
`timescale 1ns/1ps
module uart_thre_tx_bench;
  logic clk = 1'b0, rst = 1'b1;
  logic thr_wr = 0, fcr_wr = 0, fcr_fifo_en = 0, ier_wr = 0, ier_thre_en = 0;
  logic iir_rd = 0, baud_tick = 0;
  logic [7:0] thr_data = 0, lsr, iir;
  logic irq, txd;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;
  logic [7:0] rx_buf [0:63];
  int rx_n = 0, stop_err = 0, bit_i = -1, tick_ctr = 0;
  logic [7:0] rx_sh = 0;

  uart_thre_tx u_uart_thre_tx (
    .clk(clk), .rst(rst), .thr_wr(thr_wr), .thr_data(thr_data), .fcr_wr(fcr_wr),
    .fcr_fifo_en(fcr_fifo_en), .ier_wr(ier_wr), .ier_thre_en(ier_thre_en),
    .iir_rd(iir_rd), .baud_tick(baud_tick), .lsr(lsr), .iir(iir), .irq(irq),
    .txd(txd));

  always #4 clk = ~clk;

  // baud tick every 4 cycles plus a line monitor sampling in tick cycles
  always @(negedge clk) begin
    tick_ctr = (tick_ctr + 1) % 4;
    baud_tick = (tick_ctr == 0) && !rst;
    if (baud_tick) begin
      if (bit_i < 0) begin
        if (txd == 1'b0) bit_i = 0;
      end else if (bit_i < 8) begin
        rx_sh[bit_i] = txd;
        bit_i = bit_i + 1;
      end else begin
        if (txd !== 1'b1) stop_err = stop_err + 1;
        if (rx_n < 64) rx_buf[rx_n] = rx_sh;
        rx_n = rx_n + 1;
        bit_i = -1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic wr_thr(input logic [7:0] d);
    thr_wr = 1; thr_data = d; @(negedge clk); thr_wr = 0;
  endtask
  task automatic wr_ier(input logic b);
    ier_wr = 1; ier_thre_en = b; @(negedge clk); ier_wr = 0;
  endtask
  task automatic wr_fcr(input logic b);
    fcr_wr = 1; fcr_fifo_en = b; @(negedge clk); fcr_wr = 0;
  endtask
  task automatic rd_iir();
    iir_rd = 1; @(negedge clk); iir_rd = 0;
  endtask
  task automatic wait_thre();
    for (int i = 0; i < 2000 && lsr[5] !== 1'b1; i++) @(negedge clk);
  endtask
  task automatic wait_idle();
    for (int i = 0; i < 4000 && lsr[6] !== 1'b1; i++) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    chk(lsr == 8'h60, "R1", "lsr after reset", lsr, 8'h60);
    chk(iir == 8'h01, "R1", "iir after reset", iir, 8'h01);
    chk(irq == 1'b0, "R1", "irq after reset", irq, 0);
    chk(txd == 1'b1, "R1", "txd idle", txd, 1);
  endtask

  task automatic t_char_single();
    int n0 = rx_n;
    wr_thr(8'hA5);
    chk(lsr[5] == 1'b0, "R2", "thre after write", lsr[5], 0);
    @(negedge clk);
    chk(lsr[5] == 1'b1, "R2", "thre after transfer", lsr[5], 1);
    chk(lsr[6] == 1'b0, "R8", "temt while sending", lsr[6], 0);
    chk(txd == 1'b0, "R7", "start bit", txd, 0);
    chk(irq == 1'b0, "R4", "irq with enable off", irq, 0);
    wr_ier(1'b1);
    chk(irq == 1'b1, "R4", "irq on enable rise", irq, 1);
    chk(iir == 8'h02, "R5", "iir pending char mode", iir, 8'h02);
    rd_iir();
    chk(irq == 1'b0, "R6", "irq after iir read", irq, 0);
    chk(iir == 8'h01, "R5", "iir idle", iir, 8'h01);
    wait_idle();
    chk(irq == 1'b0, "R6", "no re-raise at frame end", irq, 0);
    chk(rx_n == n0 + 1 && rx_buf[n0] == 8'hA5, "R7", "frame byte", rx_buf[n0], 8'hA5);
    chk(lsr == 8'h60, "R8", "lsr idle", lsr, 8'h60);
  endtask

  task automatic t_char_full();
    int n0 = rx_n;
    wr_thr(8'h3C);
    @(negedge clk);
    chk(irq == 1'b1, "R4", "irq on transfer", irq, 1);
    wr_thr(8'hC3);
    chk(irq == 1'b0, "R6", "irq cleared by write", irq, 0);
    wr_thr(8'h77);
    repeat (3) @(negedge clk);
    chk(lsr[5] == 1'b0, "R2", "holding stays full", lsr[5], 0);
    wait_thre();
    chk(irq == 1'b1, "R4", "irq when held char moves", irq, 1);
    wait_idle();
    chk(rx_n == n0 + 2, "R2", "frames after overfill", rx_n - n0, 2);
    chk(rx_buf[n0] == 8'h3C && rx_buf[n0+1] == 8'hC3, "R2", "overfill byte dropped",
        rx_buf[n0+1], 8'hC3);
  endtask

  task automatic t_fifo();
    int n0 = rx_n;
    bit ord_ok = 1;
    rd_iir();
    wr_fcr(1'b1);
    chk(iir == 8'hC1, "R5", "iir fifo mode idle", iir, 8'hC1);
    thr_wr = 1;
    for (int i = 0; i < 18; i++) begin
      thr_data = 8'h10 + 8'(i);
      @(negedge clk);
    end
    thr_wr = 0;
    chk(lsr[5] == 1'b0, "R3", "thre with fifo loaded", lsr[5], 0);
    chk(irq == 1'b0, "R6", "irq cleared by writes", irq, 0);
    repeat (200) @(negedge clk);
    chk(irq == 1'b0 && lsr[5] == 1'b0, "R3", "not empty midway", irq, 0);
    wait_thre();
    chk(irq == 1'b1, "R4", "irq on fifo drained", irq, 1);
    chk(iir == 8'hC2, "R5", "iir pending fifo mode", iir, 8'hC2);
    wait_idle();
    chk(rx_n == n0 + 17, "R3", "accepted count", rx_n - n0, 17);
    for (int i = 0; i < 17; i++)
      if (rx_buf[n0+i] != 8'h10 + 8'(i)) ord_ok = 0;
    chk(ord_ok, "R10", "fifo order", ord_ok, 1);
  endtask

  task automatic t_iir_reraise();
    rd_iir();
    chk(irq == 1'b0, "R6", "cleared by read", irq, 0);
    repeat (60) @(negedge clk);
    chk(irq == 1'b0, "R6", "stays clear", irq, 0);
    wr_thr(8'h5A);
    chk(irq == 1'b0, "R6", "write while clear", irq, 0);
    @(negedge clk);
    chk(irq == 1'b1, "R4", "raised on new empty event", irq, 1);
    wait_idle();
  endtask

  task automatic t_flush();
    int n0 = rx_n;
    rd_iir();
    wr_thr(8'h81); wr_thr(8'h82); wr_thr(8'h83);
    chk(lsr[5] == 1'b0, "R3", "fifo holds bytes", lsr[5], 0);
    wr_fcr(1'b0);
    chk(lsr[5] == 1'b1, "R9", "flushed on mode change", lsr[5], 1);
    chk(iir == 8'h02, "R5", "iir char mode pending", iir, 8'h02);
    wait_idle();
    chk(rx_n == n0 + 1 && rx_buf[n0] == 8'h81, "R9", "only shifter byte sent",
        rx_n - n0, 1);
    chk(stop_err == 0, "R7", "stop bits", stop_err, 0);
  endtask

  always @(negedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: actual %0d expected < 100000 cycles", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_char_single();
    t_char_full();
    t_fifo();
    t_iir_reraise();
    t_flush();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule